// File: doc/BRIEF.md
# Iterative Carry-Loop Adder

This block adds or subtracts two 32-bit words over several clock cycles and never builds a ripple chain. When a request is accepted it forms a partial-sum word, which is the bitwise XOR of the operands, and a carry word, which is their bitwise AND. On each clock while the carry word is nonzero it runs one step. The step shifts the carry word left by one place, XORs it into the partial sum, and ANDs it with the old partial sum to give the next carry word. When no carries are left, the partial sum is the answer. The latency therefore depends on the data: operands with no overlapping ones finish with no steps at all.

Subtraction adds the inverted second operand. The two's-complement "+1" enters as a pending carry-in that lands in bit 0 on the first shift, so the block needs no second adder. Results wrap modulo 2^32 and there is no overflow indication.

The request side behaves like a valid/ready pair. `start` acts as valid, and the block is ready exactly when `busy` is low. A `start` seen while `busy` is high is dropped; the block does not queue it. The response side has no back-pressure. `done` pulses for one cycle, and `result` and `iters` then hold until the next accepted request.

Top module: `carry_loop_adder`

## Requirements
- R1: While `rst` is high on a clock edge, the following edge leaves `busy`=0, `done`=0, `result`=0 and `iters`=0.
- R2: `start` is accepted only on an edge where `busy` is low. A `start` on any other edge, including the `done` cycle, changes neither `result` nor `iters`.
- R3: With `sub`=0 the final `result` is (`op_a` + `op_b`) mod 2^32. A carry out of bit 31 is dropped with no indication.
- R4: With `sub`=1 the final `result` is (`op_a` - `op_b`) mod 2^32. It is formed as `op_a` + ~`op_b` with a carry-in of 1 that enters bit 0 on the first step.
- R5: `iters` counts the steps. It is 0 after acceptance, and each step adds 1 while the carry word (including a pending carry-in) is nonzero. Each step shifts the carry left, dropping bit 31, sets sum = sum ^ shifted and sets carry = shifted & old sum.
- R6: Additions end within 32 steps and subtractions within 33 steps.
- R7: `done` is high for exactly one cycle. It is sampled high N+2 cycles after the accepting edge, where N is the step count, and this includes N=0.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle, and low in the cycle after `done`.
- R9: After `done`, `result` and `iters` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe (valid); taken only while `busy` is low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 = subtract `op_b` from `op_a`, 0 = add |
| result | output | 32 | Partial sum while running; final value once `done` is high |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in progress; its inverse is the ready signal |
| iters | output | 6 | Number of steps used by the current or last request |

## Verification
The completion pulse and a fresh request strobe can land in the same cycle. The `done` cycle still counts as busy, so a `start` there must be dropped and must not be taken as a back-to-back request. The bench provokes this by holding `start` high through an entire operation while it swaps the operands for different values. It then checks, in the idle cycle that follows, that `result` and `iters` still show the original answer. The table also covers the extremes of the step count: zero steps, 32 steps for an addition whose carry runs the full width, and 33 steps for a subtraction whose injected carry-in does the same.

// File: rtl/clp_pkg.sv
package clp_pkg;

  // Control states of the carry-loop sequencer
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_DONE = 2'd2
  } clp_state_e;

endpackage

// File: rtl/clp_seed.sv
// Forms the starting partial sum and carry word for a new request.
// The carry word is W+1 bits: bit 0 holds a pending carry-in that the
// first shift moves into bit 0 of the sum; bits W:1 hold the carries.
module clp_seed #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum0,
  output logic [W:0]   car0
);

  logic [W-1:0] b_eff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i]   = b[i] ^ sub;
    assign sum0[i]    = a[i] ^ b_eff[i];
    assign car0[i+1]  = a[i] & b_eff[i];
  end

  // two's-complement plus-one rides in as a carry below bit 0
  assign car0[0] = sub;

endmodule

// File: rtl/clp_step.sv
// One shift-and-combine step of the carry loop, one half-adder per bit.
module clp_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] sum_i,
  input  logic [W:0]   car_i,
  output logic [W-1:0] sum_o,
  output logic [W:0]   car_o,
  output logic         car_zero
);

  // Shifting left by one drops the top carry and brings the pending
  // carry-in into bit 0: exactly the low W bits of the extended word.
  logic [W-1:0] shifted;
  assign shifted = car_i[W-1:0];

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign sum_o[i]   = sum_i[i] ^ shifted[i];
    assign car_o[i+1] = sum_i[i] & shifted[i];
  end

  // after a step there is never a pending carry-in
  assign car_o[0] = 1'b0;

  assign car_zero = ~|car_i;

endmodule

// File: rtl/clp_ctrl.sv
// Sequencer: idle -> loop (one step per clock while carries remain) -> done.
module clp_ctrl
  import clp_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          car_zero,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] iters
);

  clp_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    load = (st_q == ST_IDLE) && start;
    step = (st_q == ST_LOOP) && !car_zero;
    busy = (st_q != ST_IDLE);
    done = (st_q == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_LOOP;
            cnt_q <= '0;
          end
        end
        ST_LOOP: begin
          if (car_zero) st_q  <= ST_DONE;
          else          cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign iters = cnt_q;

endmodule

// File: rtl/carry_loop_adder.sv
// Multi-cycle XOR/AND carry-loop adder/subtractor.
module carry_loop_adder #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          sub,
  output logic [W-1:0]  result,
  output logic          done,
  output logic          busy,
  output logic [CW-1:0] iters
);

  logic [W-1:0] sum_q, sum_seed, sum_next;
  logic [W:0]   car_q, car_seed, car_next;
  logic         car_zero, load, step;

  clp_seed #(.W(W)) u_seed (
    .a    (op_a),
    .b    (op_b),
    .sub  (sub),
    .sum0 (sum_seed),
    .car0 (car_seed)
  );

  clp_step #(.W(W)) u_step (
    .sum_i    (sum_q),
    .car_i    (car_q),
    .sum_o    (sum_next),
    .car_o    (car_next),
    .car_zero (car_zero)
  );

  clp_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .car_zero (car_zero),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .iters    (iters)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      car_q <= '0;
    end else if (load) begin
      sum_q <= sum_seed;
      car_q <= car_seed;
    end else if (step) begin
      sum_q <= sum_next;
      car_q <= car_next;
    end
  end

  assign result = sum_q;

endmodule

// File: rtl/carry_loop_adder_chk.sv
module carry_loop_adder_chk #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [W-1:0]  result,
  input logic          done,
  input logic          busy,
  input logic [CW-1:0] iters
);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  a_r6_step_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(iters) <= W + 1));

  a_r2_accept_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(iters)));

  a_r5_count_by_one: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (iters == $past(iters) || iters == $past(iters) + 1'b1));

endmodule

bind carry_loop_adder carry_loop_adder_chk #(.W(W), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .result (result),
  .done   (done),
  .busy   (busy),
  .iters  (iters)
);

// File: tb/carry_loop_adder_test.sv
`timescale 1ns/1ps
module carry_loop_adder_test;

  localparam int W  = 32;
  localparam int CW = 6;

  typedef struct packed {
    logic        sub;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [7:0]  it;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'd0},
    '{1'b0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008, 8'd3},
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 8'd32},
    '{1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 8'd1},
    '{1'b0, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678, 8'd0},
    '{1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 8'd31},
    '{1'b1, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 8'd29},
    '{1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'd33},
    '{1'b1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 8'd2},
    '{1'b1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 8'd1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          sub = 1'b0;
  logic [W-1:0]  result;
  logic          done;
  logic          busy;
  logic [CW-1:0] iters;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  carry_loop_adder #(.W(W)) uut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .sub    (sub),
    .result (result),
    .done   (done),
    .busy   (busy),
    .iters  (iters)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one request; with hold=1, start stays high (and operands are
  // scrambled) until after the done cycle, so every extra strobe must be dropped.
  task automatic run_op(input vec_t v, input bit hold);
    int cyc;
    string rq;
    rq = v.sub ? "R4" : "R3";
    @(negedge clk);
    op_a  = v.a;
    op_b  = v.b;
    sub   = v.sub;
    start = 1'b1;
    cyc   = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        op_a = ~v.a;
        op_b = v.b + 32'd7;
        sub  = ~v.sub;
      end else begin
        start = 1'b0;
      end
      if (cyc == 1) chk(busy === 1'b1, "R8", "busy after accept", 32'(busy), 32'd1);
      if (done === 1'b1) break;
    end
    chk(cyc == int'(v.it) + 2, "R7", "done latency", 32'(cyc), 32'(v.it) + 32'd2);
    chk(result === v.res, rq, "result", result, v.res);
    chk(iters === CW'(v.it), "R5", "step count", 32'(iters), 32'(v.it));
    chk(int'(iters) <= (v.sub ? 33 : 32), "R6", "step bound", 32'(iters),
        v.sub ? 32'd33 : 32'd32);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0, "R7", "done single cycle", 32'(done), 32'd0);
    chk(busy === 1'b0, "R8", "busy clear after done", 32'(busy), 32'd0);
    chk(result === v.res, hold ? "R2" : "R9", "result after done", result, v.res);
    chk(iters === CW'(v.it), hold ? "R2" : "R9", "count after done", 32'(iters), 32'(v.it));
    @(negedge clk);
    chk(result === v.res, "R9", "result held", result, v.res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    chk(result === '0, "R1", "result in reset", result, 32'd0);
    chk(iters === '0, "R1", "count in reset", 32'(iters), 32'd0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

    // R2: start held through the done cycle must be dropped
    run_op(VECS[1], 1'b1);
    run_op(VECS[8], 1'b1);

    // back-to-back acceptance right after idle returns (R2)
    run_op(VECS[9], 1'b0);
    run_op(VECS[2], 1'b0);

    // R1: synchronous reset in the middle of a long request
    @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; sub = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R8", "busy mid-run", 32'(busy), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after mid reset", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1", "done after mid reset", 32'(done), 32'd0);
    chk(result === '0, "R1", "result after mid reset", result, 32'd0);
    chk(iters === '0, "R1", "count after mid reset", 32'(iters), 32'd0);
    rst = 1'b0;

    run_op(VECS[6], 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule